// File: doc/BRIEF.md
# Multithreaded Fetch Slot Arbiter

This block decides, each cycle, which hardware thread of a multithreaded front end may use the single instruction fetch slot. Every thread reports a fetch-state code, an active bit and two occupancy counts: one for its issue-queue entries and one for its load/store-queue entries. A static two-bit policy input chooses among four arbitration schemes: a fixed thread, a rotating order, fewest issue-queue entries, and fewest load/store entries.

The result is a valid flag and a thread index. Both are computed combinationally from the inputs and from the registered rotation order. When the consumer takes the granted slot it raises an accept strobe. Under the rotating policy, that strobe moves the granted thread to the back of the order. When no thread qualifies, the valid flag stays low and the fetch unit idles for that cycle.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when it is active and its 3-bit state code is 0 (running), 1 (idle) or 6 (line returned). Codes 2 (blocked), 3 (squashing), 4 (awaiting response), 5 (awaiting retry) and 7 (parked) never qualify.
- R2: A thread whose bit in `thr_active` is 0 is never selected, whatever its state code or counts.
- R3: When no thread is eligible, `sel_valid` is 0.
- R4: Policy code 0 (fixed) is illegal when more than one thread is configured and then gives no selection. With one thread configured it grants thread 0 whenever thread 0 is eligible.
- R5: After reset the rotation order is thread 0, 1, 2, ... ascending. Under policy code 1 (rotating) with every thread eligible, the first grant is thread 0.
- R6: Under policy code 1, the grant goes to the first eligible thread found when the rotation order is scanned from its head.
- R7: Under policy code 1, a cycle with `grant_accept` high and `sel_valid` high takes the granted thread out of its place in the order and appends it at the tail. The other threads keep their relative order.
- R8: The rotation order changes only on a cycle in which `grant_accept` is high. With stable inputs and no accept, the grant holds.
- R9: Under policy code 2, the grant goes to the eligible thread with the smallest issue-queue count.
- R10: Under policy code 3, the grant goes to the eligible thread with the smallest load/store-queue count.
- R11: In the occupancy policies, a tie on the count goes to the lower thread index.
- R12: An accept under policy code 0, 2 or 3 leaves the rotation order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_state | input | 3*NUM_THR | Per-thread fetch-state code; thread i occupies bits [3i+2:3i] |
| thr_active | input | NUM_THR | Per-thread active bit |
| iq_occ | input | CNT_W*NUM_THR | Per-thread issue-queue entry count; thread i occupies slice i |
| lsq_occ | input | CNT_W*NUM_THR | Per-thread load/store-queue entry count; thread i occupies slice i |
| policy_sel | input | 2 | 0 fixed, 1 rotating, 2 fewest issue-queue, 3 fewest load/store |
| grant_accept | input | 1 | Consumer takes the current grant this cycle |
| sel_valid | output | 1 | A thread is granted this cycle |
| sel_thread | output | TID_W | Index of the granted thread |

## Verification
The functions that can meet in one cycle are the tail move of the rotation order and the scan that picks the next grant. An accept updates the order at the clock edge, and in the next cycle the scan must already see the new order while eligibility is changing. This case is provoked by accepting a grant and, in the next cycle, making the thread that became the new head ineligible. The scoreboard's own model of the order then predicts which thread lies deeper in the list and should win. Accepts under the occupancy policies are mixed in as well, and they must leave the later rotating grants exactly as the untouched model expects.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;

  typedef enum logic [2:0] {
    FS_RUN        = 3'd0,
    FS_IDLE       = 3'd1,
    FS_BLOCK      = 3'd2,
    FS_SQUASH     = 3'd3,
    FS_WAIT_RESP  = 3'd4,
    FS_WAIT_RETRY = 3'd5,
    FS_LINE_READY = 3'd6,
    FS_PARKED     = 3'd7
  } fstate_e;

  typedef enum logic [1:0] {
    POL_FIXED = 2'd0,
    POL_RR    = 2'd1,
    POL_IQ    = 2'd2,
    POL_LSQ   = 2'd3
  } policy_e;

  localparam int STATE_W = 3;

endpackage

// File: rtl/fts_elig.sv
`timescale 1ns/1ps
module fts_elig #(
  parameter int NUM_THR = 4
) (
  input  logic [fts_pkg::STATE_W*NUM_THR-1:0] thr_state,
  input  logic [NUM_THR-1:0]                  thr_active,
  output logic [NUM_THR-1:0]                  elig
);
  import fts_pkg::*;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    logic [STATE_W-1:0] code;
    assign code = thr_state[g*STATE_W +: STATE_W];
    always_comb begin
      unique case (fstate_e'(code))
        FS_RUN, FS_IDLE, FS_LINE_READY: elig[g] = thr_active[g];
        default:                        elig[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fts_rr_list.sv
`timescale 1ns/1ps
module fts_rr_list #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] elig,
  input  logic               upd_en,
  output logic               found,
  output logic [TID_W-1:0]   pick
);

  logic [TID_W-1:0] order_q [NUM_THR];
  logic [TID_W-1:0] order_d [NUM_THR];
  logic [TID_W-1:0] hit_pos;

  // scan from the tail toward the head so the head-most hit wins
  always_comb begin
    found   = 1'b0;
    hit_pos = '0;
    pick    = '0;
    for (int p = NUM_THR - 1; p >= 0; p--) begin
      if (elig[order_q[p]]) begin
        found   = 1'b1;
        hit_pos = TID_W'(p);
        pick    = order_q[p];
      end
    end
  end

  // next order: close the gap left by the granted entry, put it last
  always_comb begin
    for (int i = 0; i < NUM_THR; i++) order_d[i] = order_q[i];
    if (upd_en && found) begin
      for (int i = 0; i < NUM_THR - 1; i++) begin
        if (i >= int'(hit_pos)) order_d[i] = order_q[i+1];
      end
      order_d[NUM_THR-1] = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THR; i++) order_q[i] <= TID_W'(i);
    end else if (upd_en) begin
      for (int i = 0; i < NUM_THR; i++) order_q[i] <= order_d[i];
    end
  end

endmodule

// File: rtl/fts_occ_pick.sv
`timescale 1ns/1ps
module fts_occ_pick #(
  parameter int NUM_THR = 4,
  parameter int CNT_W   = 6,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR-1:0]       elig,
  input  logic [CNT_W*NUM_THR-1:0] cnt_vec,
  output logic                     found,
  output logic [TID_W-1:0]         pick
);

  logic [CNT_W-1:0] best;

  // strict less-than keeps the earlier (lower) index on a tie
  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '1;
    for (int i = 0; i < NUM_THR; i++) begin
      if (elig[i] && (!found || cnt_vec[i*CNT_W +: CNT_W] < best)) begin
        found = 1'b1;
        pick  = TID_W'(i);
        best  = cnt_vec[i*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/fetch_thread_sel.sv
`timescale 1ns/1ps
module fetch_thread_sel #(
  parameter  int NUM_THR = 4,
  parameter  int CNT_W   = 6,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3*NUM_THR-1:0]       thr_state,
  input  logic [NUM_THR-1:0]         thr_active,
  input  logic [CNT_W*NUM_THR-1:0]   iq_occ,
  input  logic [CNT_W*NUM_THR-1:0]   lsq_occ,
  input  logic [1:0]                 policy_sel,
  input  logic                       grant_accept,
  output logic                       sel_valid,
  output logic [TID_W-1:0]           sel_thread
);
  import fts_pkg::*;

  logic [NUM_THR-1:0] elig;
  logic               rr_found, iq_found, lsq_found, fix_valid;
  logic [TID_W-1:0]   rr_pick, iq_pick, lsq_pick;
  logic               rr_upd;

  fts_elig #(.NUM_THR(NUM_THR)) u_elig (
    .thr_state  (thr_state),
    .thr_active (thr_active),
    .elig       (elig)
  );

  assign rr_upd = grant_accept && (policy_e'(policy_sel) == POL_RR);

  fts_rr_list #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig   (elig),
    .upd_en (rr_upd),
    .found  (rr_found),
    .pick   (rr_pick)
  );

  fts_occ_pick #(.NUM_THR(NUM_THR), .CNT_W(CNT_W), .TID_W(TID_W)) u_iq (
    .elig    (elig),
    .cnt_vec (iq_occ),
    .found   (iq_found),
    .pick    (iq_pick)
  );

  fts_occ_pick #(.NUM_THR(NUM_THR), .CNT_W(CNT_W), .TID_W(TID_W)) u_lsq (
    .elig    (elig),
    .cnt_vec (lsq_occ),
    .found   (lsq_found),
    .pick    (lsq_pick)
  );

  if (NUM_THR == 1) begin : g_fix_single
    assign fix_valid = elig[0];
  end else begin : g_fix_illegal
    assign fix_valid = 1'b0;
  end

  always_comb begin
    sel_valid  = 1'b0;
    sel_thread = '0;
    unique case (policy_e'(policy_sel))
      POL_FIXED: begin sel_valid = fix_valid; sel_thread = '0;       end
      POL_RR:    begin sel_valid = rr_found;  sel_thread = rr_pick;  end
      POL_IQ:    begin sel_valid = iq_found;  sel_thread = iq_pick;  end
      POL_LSQ:   begin sel_valid = lsq_found; sel_thread = lsq_pick; end
      default:   begin sel_valid = 1'b0;      sel_thread = '0;       end
    endcase
  end

endmodule

// File: rtl/fetch_thread_sel_chk.sv
`timescale 1ns/1ps
module fetch_thread_sel_chk #(
  parameter  int NUM_THR = 4,
  parameter  int CNT_W   = 6,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [3*NUM_THR-1:0]     thr_state,
  input logic [NUM_THR-1:0]       thr_active,
  input logic [CNT_W*NUM_THR-1:0] iq_occ,
  input logic [CNT_W*NUM_THR-1:0] lsq_occ,
  input logic [1:0]               policy_sel,
  input logic                     grant_accept,
  input logic                     sel_valid,
  input logic [TID_W-1:0]         sel_thread
);

  logic [NUM_THR-1:0] ok;
  logic [2:0]         sel_code;
  logic               iq_better, lsq_better;

  always_comb begin
    for (int i = 0; i < NUM_THR; i++) begin
      ok[i] = thr_active[i] && (thr_state[3*i +: 3] == 3'd0 ||
              thr_state[3*i +: 3] == 3'd1 || thr_state[3*i +: 3] == 3'd6);
    end
    sel_code = thr_state[3*sel_thread +: 3];
  end

  always_comb begin
    iq_better  = 1'b0;
    lsq_better = 1'b0;
    for (int j = 0; j < NUM_THR; j++) begin
      if (ok[j] && (iq_occ[j*CNT_W +: CNT_W] < iq_occ[sel_thread*CNT_W +: CNT_W] ||
          (iq_occ[j*CNT_W +: CNT_W] == iq_occ[sel_thread*CNT_W +: CNT_W] && j < int'(sel_thread))))
        iq_better = 1'b1;
      if (ok[j] && (lsq_occ[j*CNT_W +: CNT_W] < lsq_occ[sel_thread*CNT_W +: CNT_W] ||
          (lsq_occ[j*CNT_W +: CNT_W] == lsq_occ[sel_thread*CNT_W +: CNT_W] && j < int'(sel_thread))))
        lsq_better = 1'b1;
    end
  end

  assert_state_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_code == 3'd0 || sel_code == 3'd1 || sel_code == 3'd6));

  assert_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> thr_active[sel_thread]);

  assert_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok == '0) |-> !sel_valid);

  if (NUM_THR > 1) begin : g_fix
    assert_fixed_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == 2'd0) |-> !sel_valid);
  end

  assert_rr_found_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'd1 && ok != '0) |-> sel_valid);

  assert_rr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'd1 && !grant_accept) ##1
    ($stable(thr_state) && $stable(thr_active) && $stable(policy_sel))
    |-> $stable(sel_thread) && $stable(sel_valid));

  // ties toward the lower index are covered too (R11)
  assert_iq_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'd2 && sel_valid) |-> !iq_better);

  assert_lsq_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel == 2'd3 && sel_valid) |-> !lsq_better);

endmodule

bind fetch_thread_sel fetch_thread_sel_chk #(.NUM_THR(NUM_THR), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fetch_thread_sel_tb.sv
`timescale 1ns/1ps
module fetch_thread_sel_tb;

  localparam int NT = 4;
  localparam int CW = 5;

  typedef struct {
    bit         v;
    int         t;
    string      req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3*NT-1:0] st;
  logic [NT-1:0]   act;
  logic [CW*NT-1:0] iq, lsq;
  logic [1:0]      pol;
  logic            acc;
  logic            sel_valid;
  logic [1:0]      sel_thread;

  logic [2:0]      st1;
  logic            act1;
  logic            v1;
  logic [0:0]      t1;

  int errors = 0;
  int checks = 0;
  int m_order [NT];
  exp_t q[$];

  always #2 clk = ~clk;

  fetch_thread_sel #(.NUM_THR(NT), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_state(st), .thr_active(act),
    .iq_occ(iq), .lsq_occ(lsq), .policy_sel(pol), .grant_accept(acc),
    .sel_valid(sel_valid), .sel_thread(sel_thread));

  fetch_thread_sel #(.NUM_THR(1), .CNT_W(CW)) u_one (
    .clk(clk), .rst_n(rst_n), .thr_state(st1), .thr_active(act1),
    .iq_occ('0), .lsq_occ('0), .policy_sel(2'd0), .grant_accept(1'b0),
    .sel_valid(v1), .sel_thread(t1));

  function automatic bit el(int i);
    logic [2:0] c;
    c = st[3*i +: 3];
    return act[i] && (c == 3'd0 || c == 3'd1 || c == 3'd6);
  endfunction

  function automatic exp_t model(string req);
    exp_t e;
    int best;
    e.v = 0; e.t = 0; e.req = req; best = 0;
    if (pol == 2'd1) begin
      for (int p = NT - 1; p >= 0; p--)
        if (el(m_order[p])) begin e.v = 1; e.t = m_order[p]; end
    end else if (pol != 2'd0) begin
      for (int i = 0; i < NT; i++) begin
        int c;
        c = (pol == 2'd2) ? int'(iq[i*CW +: CW]) : int'(lsq[i*CW +: CW]);
        if (el(i) && (!e.v || c < best)) begin e.v = 1; e.t = i; best = c; end
      end
    end
    return e;
  endfunction

  task automatic rotate(int t);
    int pos;
    pos = 0;
    for (int i = 0; i < NT; i++) if (m_order[i] == t) pos = i;
    for (int i = pos; i < NT - 1; i++) m_order[i] = m_order[i+1];
    m_order[NT-1] = t;
  endtask

  // one stimulus cycle: drive at negedge, push expectation, commit at posedge
  task automatic step(logic [3*NT-1:0] s, logic [NT-1:0] a, logic [CW*NT-1:0] qi,
                      logic [CW*NT-1:0] ql, logic [1:0] p, logic ac, string req);
    exp_t e;
    @(negedge clk);
    st = s; act = a; iq = qi; lsq = ql; pol = p; acc = ac;
    #1;
    e = model(req);
    q.push_back(e);
    @(posedge clk);
    if (ac && e.v && p == 2'd1 && rst_n) rotate(e.t);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() != 0);
      e = q.pop_front();
      checks++;
      if (sel_valid !== e.v || (e.v && int'(sel_thread) != e.t)) begin
        errors++;
        $display("FAIL %s: got valid=%0b thr=%0d expected valid=%0b thr=%0d",
                 e.req, sel_valid, sel_thread, e.v, e.t);
      end
    end
  end

  task automatic check_one(bit ev, string req);
    #1;
    checks++;
    if (v1 !== ev || (ev && t1 !== 1'b0)) begin
      errors++;
      $display("FAIL %s: got valid=%0b thr=%0d expected valid=%0b thr=0", req, v1, t1, ev);
    end
  endtask

  localparam logic [11:0] ALL_RUN = 12'h000;
  localparam logic [19:0] Z = 20'h0;

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < NT; i++) m_order[i] = i;
    rst_n = 1'b0; st1 = 3'd0; act1 = 1'b1;
    // R5: reset order ascending, first grant thread 0 (also checked during reset)
    step(ALL_RUN, 4'hF, Z, Z, 2'd1, 1'b0, "R5 reset order");
    @(negedge clk); rst_n = 1'b1;
    step(ALL_RUN, 4'hF, Z, Z, 2'd1, 1'b0, "R5 first grant");
    // R7: accepts rotate 0,1,2,3,0
    for (int k = 0; k < 5; k++) step(ALL_RUN, 4'hF, Z, Z, 2'd1, 1'b1, "R7 rotate");
    // R8: no accept, grant holds
    for (int k = 0; k < 3; k++) step(ALL_RUN, 4'hF, Z, Z, 2'd1, 1'b0, "R8 hold");
    // R6 with R7: accept then make new head ineligible (thread 2 blocked)
    step(ALL_RUN, 4'hF, Z, Z, 2'd1, 1'b1, "R7 accept before skip");
    step({3'd0, 3'd2, 3'd0, 3'd0}, 4'hF, Z, Z, 2'd1, 1'b0, "R6 skip blocked head");
    step({3'd0, 3'd2, 3'd0, 3'd3}, 4'hF, Z, Z, 2'd1, 1'b1, "R6 skip two");
    // R1: ineligible codes everywhere -> none (R3)
    step({3'd2, 3'd3, 3'd4, 3'd5}, 4'hF, Z, Z, 2'd1, 1'b0, "R1 codes 2-5");
    step({3'd7, 3'd7, 3'd7, 3'd7}, 4'hF, Z, Z, 2'd1, 1'b1, "R3 all parked");
    step({3'd6, 3'd4, 3'd5, 3'd7}, 4'hF, Z, Z, 2'd1, 1'b0, "R1 line ready");
    step({3'd4, 3'd1, 3'd5, 3'd2}, 4'hF, Z, Z, 2'd1, 1'b0, "R1 idle");
    // R2: inactive threads ignored
    step(ALL_RUN, 4'h0, Z, Z, 2'd1, 1'b0, "R2 none active");
    step(ALL_RUN, 4'h4, Z, Z, 2'd2, 1'b0, "R2 only thread 2");
    step(ALL_RUN, 4'h6, {5'd0, 5'd9, 5'd4, 5'd0}, Z, 2'd2, 1'b0, "R2 inactive low count");
    // R4: fixed policy illegal with four threads
    step(ALL_RUN, 4'hF, Z, Z, 2'd0, 1'b1, "R4 fixed illegal");
    // R9 / R11
    step(ALL_RUN, 4'hF, {5'd3, 5'd7, 5'd3, 5'd5}, Z, 2'd2, 1'b0, "R11 iq tie");
    step(ALL_RUN, 4'hF, {5'd8, 5'd2, 5'd6, 5'd9}, Z, 2'd2, 1'b1, "R9 iq min");
    step({3'd0, 3'd3, 3'd0, 3'd0}, 4'hF, {5'd8, 5'd1, 5'd6, 5'd9}, Z, 2'd2, 1'b0, "R9 min blocked");
    // R10 / R11
    step(ALL_RUN, 4'hF, Z, {5'd1, 5'd4, 5'd0, 5'd4}, 2'd3, 1'b1, "R10 lsq min");
    step(ALL_RUN, 4'hF, {5'd0, 5'd0, 5'd0, 5'd0}, {5'd2, 5'd2, 5'd2, 5'd2}, 2'd3, 1'b0, "R11 lsq all equal");
    // R12: order untouched by occupancy/fixed accepts
    for (int k = 0; k < 4; k++) step(ALL_RUN, 4'hF, Z, Z, 2'd1, 1'b1, "R12 order after other modes");
    // R4 single-thread configuration
    @(negedge clk); st1 = 3'd0; act1 = 1'b1; check_one(1'b1, "R4 one thread running");
    @(negedge clk); st1 = 3'd4; check_one(1'b0, "R4 one thread waiting");
    @(negedge clk); st1 = 3'd6; act1 = 1'b0; check_one(1'b0, "R4 one thread inactive");
    @(negedge clk); act1 = 1'b1; check_one(1'b1, "R4 one thread line ready");
    wait (q.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule